// File: doc/BRIEF.md
# Core Module Control Register Bank

This block is the register file of a processor core module. A simple word-addressed bus reaches it. Bits [1:0] of the byte address are ignored, and the remaining bits pick one 32-bit register. Reads are combinational: `bus_rdata` shows the addressed word in the same cycle. A write takes effect at the clock edge where `bus_sel` and `bus_we` are both high.

The bank holds the following state:
- oscillator settings, which only take a write after a 16-bit key has been stored;
- a control word that drives a remap output and can request a system reset;
- SDRAM and init configuration words;
- two flag words with separate set and clear addresses;
- a 32-bit reference counter, advanced by a 24 MHz strobe;
- a small local interrupt section with IRQ and FIQ enable masks and a software interrupt bit.

A read-only window at byte offsets 0x100 to 0x1FF returns bytes of a constant memory-presence table.

Top module: `cm_ctrl_regbank`

## Requirements
- R1: Index 0 reads 0x411A3001, index 4 reads 0x00100000 and index 1 reads 0, whatever was written before.
- R2: After reset the registers read as follows: oscillator (index 2) 0x01000048, auxiliary oscillator (index 7) 0x0007FEFF, SDRAM (index 8) 0x00011122, init (index 9) 0x00000112. Lock, control, both flag words, both enable masks, the software bit and the counter read 0. Both outputs are low.
- R3: A write to index 5 stores bits [15:0]. A read of index 5 returns the stored value, with bit 16 set exactly when that value is 0xA05F.
- R4: Writes to index 2 and index 7 replace the whole word when the stored key equals 0xA05F. At any other key they leave the register unchanged.
- R5: The SDRAM (index 8) and init (index 9) words store every written bit.
- R6: The control word (index 3) keeps only bit 0 (indicator) and bit 2 (remap). All other bits, bit 3 included, read as 0.
- R7: A write to index 3 with bit 3 set makes `rst_req_o` high for exactly the one cycle after the write edge. Nothing else raises it.
- R8: `remap_o` equals the stored control bit 2 from the cycle after the write.
- R9: The flag word reads at index 12. A write to 12 ORs the data in, and a write to 13 clears the bits that are 1 in the data. The non-volatile flag word does the same at 14 (read and set) and 15 (clear). The two words are independent.
- R10: The IRQ enable mask reads at 18, is set by writes to 18 and cleared by writes to 19. The FIQ mask behaves the same at 26 and 27.
- R11: The interrupt level has only bit 0, the software bit. A write to 20 with data bit 0 set sets it, a write to 21 with data bit 0 set clears it, and other data bits have no effect. Indices 20, 17 and 25 read the level. Indices 16 and 24 read the level ANDed with the IRQ and FIQ masks.
- R12: Index 10 reads a 32-bit counter that increases by one on each clock edge where `tick_ref` is high.
- R13: In the byte offset range 0x100 to 0x17F, a read returns in bits [7:0] table entry (offset >> 2). Entry 64 is 0x80, entry 65 is 0x08, and entries 73 to 83 hold the ASCII text "CORE-MODULE". All other entries are 0. Offsets 0x180 to 0x1FF read 0, and writes to the window are ignored.
- R14: Every other index reads 0 and ignores writes. This covers index 6, indices 32 to 35, the clear-only indices, and addresses at or above 0x200.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address, bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| tick_ref | input | 1 | 24 MHz count enable, synchronous to clk |
| remap_o | output | 1 | Remap state, high hides the flash alias at zero |
| rst_req_o | output | 1 | One-cycle reset request pulse |

## Verification
Every stored value is visible on `bus_rdata` as soon as the next read is issued, one cycle after the write edge. A lost or wrongly gated write therefore shows up at the first read-back. A key comparison that fails to open or close is seen as an oscillator value that did change or did not change. A set/clear register with a wrong mask shows up as extra or missing bits in its readback. A stuck reset-request register is seen on `rst_req_o` in the second cycle after the control write. A miscounting counter shows a wrong difference after a known number of strobes.

// File: rtl/cmreg_pkg.sv
package cmreg_pkg;

  localparam int DW    = 32;
  localparam int IDX_W = 8;
  typedef logic [IDX_W-1:0] idx_t;

  // word indices (byte address >> 2)
  localparam idx_t IDX_ID       = 8'd0;
  localparam idx_t IDX_OSC      = 8'd2;
  localparam idx_t IDX_CTRL     = 8'd3;
  localparam idx_t IDX_STAT     = 8'd4;
  localparam idx_t IDX_LOCK     = 8'd5;
  localparam idx_t IDX_AUX      = 8'd7;
  localparam idx_t IDX_SDRAM    = 8'd8;
  localparam idx_t IDX_INIT     = 8'd9;
  localparam idx_t IDX_REFCNT   = 8'd10;
  localparam idx_t IDX_FLAGS    = 8'd12;
  localparam idx_t IDX_NVFLAGS  = 8'd14;
  localparam idx_t IDX_IRQ_STAT = 8'd16;
  localparam idx_t IDX_IRQ_RAW  = 8'd17;
  localparam idx_t IDX_IRQ_EN   = 8'd18;
  localparam idx_t IDX_SOFT_SET = 8'd20;
  localparam idx_t IDX_SOFT_CLR = 8'd21;
  localparam idx_t IDX_FIQ_STAT = 8'd24;
  localparam idx_t IDX_FIQ_RAW  = 8'd25;
  localparam idx_t IDX_FIQ_EN   = 8'd26;

  // set/clear register array: set index, clear index is set index + 1
  localparam int NUM_SC  = 4;
  localparam int SC_FLAGS = 0;
  localparam int SC_NV    = 1;
  localparam int SC_IRQ   = 2;
  localparam int SC_FIQ   = 3;
  localparam idx_t SC_SET_IDX [NUM_SC] = '{IDX_FLAGS, IDX_NVFLAGS, IDX_IRQ_EN, IDX_FIQ_EN};

  // constants and reset values
  localparam logic [DW-1:0] ID_WORD    = 32'h411A_3001;
  localparam logic [DW-1:0] STAT_WORD  = 32'h0010_0000;
  localparam logic [DW-1:0] RST_OSC    = 32'h0100_0048;
  localparam logic [DW-1:0] RST_AUX    = 32'h0007_FEFF;
  localparam logic [DW-1:0] RST_SDRAM  = 32'h0001_1122;
  localparam logic [DW-1:0] RST_INIT   = 32'h0000_0112;
  localparam logic [15:0]   UNLOCK_KEY = 16'hA05F;

  localparam int CTRL_LED_BIT   = 0;
  localparam int CTRL_REMAP_BIT = 2;
  localparam int CTRL_RESET_BIT = 3;

  // presence table window
  localparam logic [87:0] SPD_ID_TEXT  = "CORE-MODULE";
  localparam int          SPD_ID_FIRST = 73;
  localparam int          SPD_ID_LEN   = 11;

  function automatic logic [DW-1:0] lock_readback(input logic [15:0] key);
    return {15'b0, (key == UNLOCK_KEY), key};
  endfunction

  function automatic logic [DW-1:0] setclr_next(input logic [DW-1:0] cur,
                                                input logic set_en,
                                                input logic clr_en,
                                                input logic [DW-1:0] d);
    logic [DW-1:0] s;
    logic [DW-1:0] c;
    s = set_en ? d : '0;
    c = clr_en ? d : '0;
    return (cur | s) & ~c;
  endfunction

  function automatic logic [7:0] spd_entry(input logic [6:0] idx);
    int k;
    k = int'(idx) - SPD_ID_FIRST;
    if (idx == 7'd64) return 8'h80;
    if (idx == 7'd65) return 8'h08;
    if (k >= 0 && k < SPD_ID_LEN) return SPD_ID_TEXT[8*(SPD_ID_LEN-1-k) +: 8];
    return 8'h00;
  endfunction

endpackage

// File: rtl/cmreg_keyed_osc.sv
module cmreg_keyed_osc
  import cmreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lock,
  input  logic          wr_osc,
  input  logic          wr_aux,
  input  logic [DW-1:0] wdata,
  output logic [15:0]   lock_q,
  output logic          unlocked,
  output logic [DW-1:0] osc_q,
  output logic [DW-1:0] aux_q
);

  assign unlocked = (lock_q == UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= '0;
      osc_q  <= RST_OSC;
      aux_q  <= RST_AUX;
    end else begin
      if (wr_lock) lock_q <= wdata[15:0];
      if (wr_osc && unlocked) osc_q <= wdata;
      if (wr_aux && unlocked) aux_q <= wdata;
    end
  end

  // R4: a locked bank keeps both oscillator words
  a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(osc_q) && $stable(aux_q)));

  // R3: key register takes the low half-word
  a_r3_key_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lock |=> (lock_q == $past(wdata[15:0])));

endmodule

// File: rtl/cmreg_setclr.sv
module cmreg_setclr
  import cmreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= setclr_next(q, set_en, clr_en, wdata);
  end

  // R9 / R10: untouched without a strobe
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en || clr_en) |=> $stable(q));

  // R9 / R10: a set write leaves every written one present
  a_r10_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> ((q & $past(wdata)) == $past(wdata)));

endmodule

// File: rtl/cmreg_refcnt.sv
module cmreg_refcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] cnt_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + W'(1);
  end

  // R12: one step per strobe, none otherwise
  a_r12_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(cnt_q) + W'(1)));
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

endmodule

// File: rtl/cm_ctrl_regbank.sv
module cm_ctrl_regbank
  import cmreg_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              tick_ref,
  output logic              remap_o,
  output logic              rst_req_o
);

  // ---------------- decode ----------------
  idx_t idx;
  logic upper_zero;
  logic spd_hit;
  logic spd_lo;
  logic wr_hit;
  logic unused_lsb;

  assign idx        = bus_addr[9:2];
  assign unused_lsb = ^bus_addr[1:0];

  if (ADDR_W > 10) begin : g_hi
    assign upper_zero = ~|bus_addr[ADDR_W-1:10];
  end else begin : g_nohi
    assign upper_zero = 1'b1;
  end

  assign spd_hit = upper_zero && (bus_addr[9:8] == 2'b01);
  assign spd_lo  = ~bus_addr[7];
  assign wr_hit  = bus_sel && bus_we && upper_zero;

  logic wr_ctrl, wr_lock, wr_osc, wr_aux, wr_sdram, wr_init;
  logic wr_soft_set, wr_soft_clr;
  assign wr_ctrl     = wr_hit && (idx == IDX_CTRL);
  assign wr_lock     = wr_hit && (idx == IDX_LOCK);
  assign wr_osc      = wr_hit && (idx == IDX_OSC);
  assign wr_aux      = wr_hit && (idx == IDX_AUX);
  assign wr_sdram    = wr_hit && (idx == IDX_SDRAM);
  assign wr_init     = wr_hit && (idx == IDX_INIT);
  assign wr_soft_set = wr_hit && (idx == IDX_SOFT_SET);
  assign wr_soft_clr = wr_hit && (idx == IDX_SOFT_CLR);

  // ---------------- keyed oscillator words ----------------
  logic [15:0]   lock_q;
  logic          unlocked;
  logic [DW-1:0] osc_q;
  logic [DW-1:0] aux_q;

  cmreg_keyed_osc u_osc (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lock  (wr_lock),
    .wr_osc   (wr_osc),
    .wr_aux   (wr_aux),
    .wdata    (bus_wdata),
    .lock_q   (lock_q),
    .unlocked (unlocked),
    .osc_q    (osc_q),
    .aux_q    (aux_q)
  );

  // ---------------- set/clear words ----------------
  logic [DW-1:0] sc_q [NUM_SC];

  for (genvar g = 0; g < NUM_SC; g++) begin : g_sc
    cmreg_setclr u_sc (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (wr_hit && (idx == SC_SET_IDX[g])),
      .clr_en (wr_hit && (idx == SC_SET_IDX[g] + 8'd1)),
      .wdata  (bus_wdata),
      .q      (sc_q[g])
    );
  end

  // ---------------- reference counter ----------------
  logic [DW-1:0] refcnt_q;

  cmreg_refcnt #(.W(DW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_ref),
    .cnt_q (refcnt_q)
  );

  // ---------------- plain registers ----------------
  logic [DW-1:0] sdram_q;
  logic [DW-1:0] init_q;
  logic          led_q;
  logic          remap_q;
  logic          rst_req_q;
  logic          soft_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sdram_q   <= RST_SDRAM;
      init_q    <= RST_INIT;
      led_q     <= 1'b0;
      remap_q   <= 1'b0;
      rst_req_q <= 1'b0;
      soft_q    <= 1'b0;
    end else begin
      if (wr_sdram) sdram_q <= bus_wdata;
      if (wr_init)  init_q  <= bus_wdata;
      if (wr_ctrl) begin
        led_q   <= bus_wdata[CTRL_LED_BIT];
        remap_q <= bus_wdata[CTRL_REMAP_BIT];
      end
      rst_req_q <= wr_ctrl && bus_wdata[CTRL_RESET_BIT];
      if (wr_soft_set && bus_wdata[0])      soft_q <= 1'b1;
      else if (wr_soft_clr && bus_wdata[0]) soft_q <= 1'b0;
    end
  end

  assign remap_o   = remap_q;
  assign rst_req_o = rst_req_q;

  // ---------------- interrupt status ----------------
  logic irq_stat_w;
  logic fiq_stat_w;
  assign irq_stat_w = soft_q & sc_q[SC_IRQ][0];
  assign fiq_stat_w = soft_q & sc_q[SC_FIQ][0];

  // ---------------- read mux ----------------
  logic [DW-1:0] rd;

  always_comb begin
    rd = '0;
    if (spd_hit) begin
      if (spd_lo) rd = {24'b0, spd_entry(bus_addr[8:2])};
    end else if (upper_zero) begin
      case (idx)
        IDX_ID:       rd = ID_WORD;
        IDX_STAT:     rd = STAT_WORD;
        IDX_OSC:      rd = osc_q;
        IDX_CTRL:     rd = {29'b0, remap_q, 1'b0, led_q};
        IDX_LOCK:     rd = lock_readback(lock_q);
        IDX_AUX:      rd = aux_q;
        IDX_SDRAM:    rd = sdram_q;
        IDX_INIT:     rd = init_q;
        IDX_REFCNT:   rd = refcnt_q;
        IDX_FLAGS:    rd = sc_q[SC_FLAGS];
        IDX_NVFLAGS:  rd = sc_q[SC_NV];
        IDX_IRQ_STAT: rd = {31'b0, irq_stat_w};
        IDX_IRQ_RAW:  rd = {31'b0, soft_q};
        IDX_IRQ_EN:   rd = sc_q[SC_IRQ];
        IDX_SOFT_SET: rd = {31'b0, soft_q};
        IDX_FIQ_STAT: rd = {31'b0, fiq_stat_w};
        IDX_FIQ_RAW:  rd = {31'b0, soft_q};
        IDX_FIQ_EN:   rd = sc_q[SC_FIQ];
        default:      rd = '0;
      endcase
    end
  end

  assign bus_rdata = rd;

  // ---------------- assertions ----------------
  // R7: a pulse is always caused by a control write with the reset bit
  a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(wr_ctrl && bus_wdata[CTRL_RESET_BIT]));

  // R8: remap output follows the written bit one cycle later
  a_r8_remap_follow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (remap_o == $past(bus_wdata[CTRL_REMAP_BIT])));

  // R11: software set raises the level
  a_r11_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_soft_set && bus_wdata[0]) |=> (bus_rdata[0] == bus_rdata[0]) && soft_q);

  // R4: oscillator words never move while the key is wrong
  a_r4_key_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_osc && !unlocked) |=> $stable(osc_q));

endmodule

// File: tb/tb_cm_ctrl_regbank.sv
`timescale 1ns/1ps
module tb_cm_ctrl_regbank;

  localparam time TCLK = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_ref = 1'b0;
  logic        remap_o;
  logic        rst_req_o;

  always #(TCLK/2) clk = ~clk;

  cm_ctrl_regbank #(.ADDR_W(10)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_ref  (tick_ref),
    .remap_o   (remap_o),
    .rst_req_o (rst_req_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic        we;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 66;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'h000, 32'h0,        32'h411A3001, 4'd1},  // R1
    '{1'b0, 10'h010, 32'h0,        32'h00100000, 4'd1},  // R1
    '{1'b0, 10'h004, 32'h0,        32'h00000000, 4'd1},  // R1
    '{1'b0, 10'h008, 32'h0,        32'h01000048, 4'd2},  // R2
    '{1'b1, 10'h008, 32'h12345678, 32'h0,        4'd4},  // R4 locked write
    '{1'b0, 10'h008, 32'h0,        32'h01000048, 4'd4},
    '{1'b1, 10'h014, 32'hFFFFA05F, 32'h0,        4'd3},  // R3 key
    '{1'b0, 10'h014, 32'h0,        32'h0001A05F, 4'd3},
    '{1'b1, 10'h008, 32'h12345678, 32'h0,        4'd4},  // R4 unlocked
    '{1'b0, 10'h008, 32'h0,        32'h12345678, 4'd4},
    '{1'b1, 10'h01C, 32'h0000ABCD, 32'h0,        4'd4},
    '{1'b0, 10'h01C, 32'h0,        32'h0000ABCD, 4'd4},
    '{1'b1, 10'h014, 32'h00001234, 32'h0,        4'd3},  // R3 relock
    '{1'b0, 10'h014, 32'h0,        32'h00001234, 4'd3},
    '{1'b1, 10'h01C, 32'h0,        32'h0,        4'd4},
    '{1'b0, 10'h01C, 32'h0,        32'h0000ABCD, 4'd4},
    '{1'b1, 10'h020, 32'hCAFEF00D, 32'h0,        4'd5},  // R5
    '{1'b0, 10'h020, 32'h0,        32'hCAFEF00D, 4'd5},
    '{1'b1, 10'h024, 32'h00000777, 32'h0,        4'd5},
    '{1'b0, 10'h024, 32'h0,        32'h00000777, 4'd5},
    '{1'b1, 10'h00C, 32'hFFFFFFF7, 32'h0,        4'd6},  // R6
    '{1'b0, 10'h00C, 32'h0,        32'h00000005, 4'd6},
    '{1'b1, 10'h00C, 32'h00000001, 32'h0,        4'd6},
    '{1'b0, 10'h00C, 32'h0,        32'h00000001, 4'd6},
    '{1'b1, 10'h030, 32'h000000F0, 32'h0,        4'd9},  // R9
    '{1'b1, 10'h030, 32'h00000003, 32'h0,        4'd9},
    '{1'b0, 10'h030, 32'h0,        32'h000000F3, 4'd9},
    '{1'b1, 10'h034, 32'h00000021, 32'h0,        4'd9},
    '{1'b0, 10'h030, 32'h0,        32'h000000D2, 4'd9},
    '{1'b1, 10'h038, 32'h80000001, 32'h0,        4'd9},
    '{1'b1, 10'h03C, 32'h00000001, 32'h0,        4'd9},
    '{1'b0, 10'h038, 32'h0,        32'h80000000, 4'd9},
    '{1'b0, 10'h030, 32'h0,        32'h000000D2, 4'd9},
    '{1'b1, 10'h048, 32'h0000000F, 32'h0,        4'd10}, // R10
    '{1'b1, 10'h04C, 32'h00000006, 32'h0,        4'd10},
    '{1'b0, 10'h048, 32'h0,        32'h00000009, 4'd10},
    '{1'b1, 10'h068, 32'h00000010, 32'h0,        4'd10},
    '{1'b0, 10'h068, 32'h0,        32'h00000010, 4'd10},
    '{1'b0, 10'h040, 32'h0,        32'h00000000, 4'd11}, // R11
    '{1'b1, 10'h050, 32'hFFFFFFFE, 32'h0,        4'd11},
    '{1'b0, 10'h050, 32'h0,        32'h00000000, 4'd11},
    '{1'b1, 10'h050, 32'h00000001, 32'h0,        4'd11},
    '{1'b0, 10'h050, 32'h0,        32'h00000001, 4'd11},
    '{1'b0, 10'h044, 32'h0,        32'h00000001, 4'd11},
    '{1'b0, 10'h040, 32'h0,        32'h00000001, 4'd11},
    '{1'b0, 10'h060, 32'h0,        32'h00000000, 4'd11},
    '{1'b0, 10'h064, 32'h0,        32'h00000001, 4'd11},
    '{1'b1, 10'h054, 32'h00000001, 32'h0,        4'd11},
    '{1'b0, 10'h044, 32'h0,        32'h00000000, 4'd11},
    '{1'b1, 10'h018, 32'hFFFFFFFF, 32'h0,        4'd14}, // R14
    '{1'b0, 10'h018, 32'h0,        32'h00000000, 4'd14},
    '{1'b1, 10'h080, 32'hFFFFFFFF, 32'h0,        4'd14},
    '{1'b0, 10'h080, 32'h0,        32'h00000000, 4'd14},
    '{1'b0, 10'h034, 32'h0,        32'h00000000, 4'd14},
    '{1'b0, 10'h20C, 32'h0,        32'h00000000, 4'd14},
    '{1'b0, 10'h008, 32'h0,        32'h12345678, 4'd14},
    '{1'b0, 10'h030, 32'h0,        32'h000000D2, 4'd14},
    '{1'b1, 10'h104, 32'hFFFFFFFF, 32'h0,        4'd13}, // R13
    '{1'b0, 10'h104, 32'h0,        32'h00000008, 4'd13},
    '{1'b0, 10'h100, 32'h0,        32'h00000080, 4'd13},
    '{1'b0, 10'h124, 32'h0,        32'h00000043, 4'd13},
    '{1'b0, 10'h12C, 32'h0,        32'h00000052, 4'd13},
    '{1'b0, 10'h14C, 32'h0,        32'h00000045, 4'd13},
    '{1'b0, 10'h150, 32'h0,        32'h00000000, 4'd13},
    '{1'b0, 10'h180, 32'h0,        32'h00000000, 4'd13},
    '{1'b0, 10'h1FC, 32'h0,        32'h00000000, 4'd13}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(TCLK * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] rv;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state
    check("R2 remap_o reset", {31'b0, remap_o}, 32'h0);
    check("R2 rst_req_o reset", {31'b0, rst_req_o}, 32'h0);
    bus_read(10'h01C, rv); check("R2 aux reset", rv, 32'h0007FEFF);
    bus_read(10'h020, rv); check("R2 sdram reset", rv, 32'h00011122);
    bus_read(10'h024, rv); check("R2 init reset", rv, 32'h00000112);
    bus_read(10'h014, rv); check("R2 lock reset", rv, 32'h0);
    bus_read(10'h00C, rv); check("R2 ctrl reset", rv, 32'h0);
    bus_read(10'h030, rv); check("R2 flags reset", rv, 32'h0);
    bus_read(10'h048, rv); check("R2 irq mask reset", rv, 32'h0);
    bus_read(10'h028, rv); check("R2 counter reset", rv, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) begin
        bus_write(VECS[i].addr, VECS[i].data);
      end else begin
        bus_read(VECS[i].addr, rv);
        check($sformatf("R%0d vec %0d", VECS[i].req, i), rv, VECS[i].exp);
      end
    end

    // R7: reset request pulse
    check("R7 idle low", {31'b0, rst_req_o}, 32'h0);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 10'h00C; bus_wdata = 32'h00000008;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    check("R7 pulse high", {31'b0, rst_req_o}, 32'h1);
    @(negedge clk);
    check("R7 pulse one cycle", {31'b0, rst_req_o}, 32'h0);
    bus_read(10'h00C, rv); check("R7 reset bit reads zero", rv, 32'h0);

    // R8: remap output
    bus_write(10'h00C, 32'h00000004);
    check("R8 remap set", {31'b0, remap_o}, 32'h1);
    check("R8 no pulse without bit3", {31'b0, rst_req_o}, 32'h0);
    bus_write(10'h00C, 32'h00000000);
    check("R8 remap clear", {31'b0, remap_o}, 32'h0);

    // R12: reference counter
    bus_read(10'h028, rv); check("R12 counter idle", rv, 32'h0);
    @(negedge clk);
    tick_ref = 1'b1;
    repeat (5) @(negedge clk);
    tick_ref = 1'b0;
    bus_read(10'h028, rv); check("R12 counter after 5 strobes", rv, 32'h5);
    repeat (3) @(negedge clk);
    bus_read(10'h028, rv); check("R12 counter holds", rv, 32'h5);

    finish_run();
  end

endmodule